// File: doc/BRIEF.md
# Register Syntactic Dependency Tracker

This block watches retired instructions in program order and records, for every general-purpose register and for a small set of tracked control/status registers, which in-flight memory operations the register's current value derives from. Each entry is a taint set: one bit per memory-operation id in a window of `WIN` ids. Taint flows through registers transitively. An ordinary instruction writes the union of its sources' taint into its destination. A load-type operation writes only its own id into its destination.

For every memory operation the block reports three bit-vectors one cycle later. The first lists the earlier operations that the address depends on. The second lists those that the store data depends on. The third lists those that any branch or jump seen so far depends on. Ordering logic uses these vectors to decide which operations must stay ordered. When an id retires, its bit is cleared from every taint set, so the id can be reused.

Top module: `memdep_tracker`

## Requirements
- R1: After reset every taint set, including the control set, is empty, and `dep_valid` is low. The first memory operation after reset reports all-zero vectors.
- R2: Register index 0 never carries taint. A write to it is dropped, and reading it as a source contributes an empty set.
- R3: A non-memory instruction (`in_mem`=0) with a nonzero `in_rd` replaces that register's taint with the union of the taints of `in_rs1`, `in_rs2` and `in_rs3`, plus that of the selected CSR when the CSR counts as a source. The old contents are not kept.
- R4: The destination of a load (`in_mem`=1), atomic read-modify-write (3), load-reserved (4) or successful store-conditional (5) takes only the bit of that operation's own id. A store (2) writes no register.
- R5: A failed store-conditional (`in_mem`=6) produces no report (`dep_valid` stays low) and leaves its destination with an empty taint set.
- R6: One cycle after a memory operation with code 1 to 5, `dep_valid` is high and `dep_id` equals its id. `dep_addr` is the taint of `in_rs1`. `dep_data` is the taint of `in_rs2` for codes 2, 3 and 5, and is zero for codes 1 and 4.
- R7: A branch or jump (`in_is_ctrl`=1) ORs the union of its source taints into a sticky control set. Every later memory operation reports that set on `dep_ctrl`.
- R8: With `in_csr_en`=1, the selected CSR counts as a source except for `in_csr_op` 0 (read-write) and 3 (read-write immediate) when `in_rd` is 0.
- R9: With `in_csr_en`=1, the selected CSR takes the source union as its new taint. This does not happen for ops 1 and 2 (set, clear), or 4 and 5 (set/clear immediate), when the `in_rs1` field is 0. For ops 3, 4 and 5, `in_rs1` holds an immediate and is never a register source.
- R10: `ret_valid` clears bit `ret_id` from every register, CSR and control taint set. The clear also applies to the report produced in the same cycle.
- R11: Taint is transitive. A value that passes through a chain of non-memory instructions keeps the ids of the loads at the chain's head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Retired instruction descriptor is present |
| in_rs1 | input | RIW | First source index (immediate for CSR immediate ops) |
| in_rs2 | input | RIW | Second source index, data source for stores |
| in_rs3 | input | RIW | Third source index |
| in_rd | input | RIW | Destination index |
| in_csr_en | input | 1 | Instruction is a CSR access |
| in_csr_op | input | 3 | CSR op: 0 rw, 1 set, 2 clear, 3 rw-imm, 4 set-imm, 5 clear-imm |
| in_csr_sel | input | CIW | Tracked CSR slot |
| in_is_ctrl | input | 1 | Branch or indirect jump |
| in_mem | input | 3 | Memory role: 0 none, 1 load, 2 store, 3 atomic, 4 load-reserved, 5 SC ok, 6 SC fail |
| in_op_id | input | IDW | Memory operation id |
| ret_valid | input | 1 | An id retires this cycle |
| ret_id | input | IDW | Retiring id |
| dep_valid | output | 1 | Report present |
| dep_id | output | IDW | Id of the reported operation |
| dep_addr | output | WIN | Address dependency set |
| dep_data | output | WIN | Data dependency set |
| dep_ctrl | output | WIN | Control dependency set |

## Verification
The bench builds the block with its defaults: a 16-id window, 32 registers and 4 tracked CSRs. With this window, ids up to 15 fit in one reporting vector. Two CSR slots are used side by side, which shows that a write to one slot leaves the other alone. Directed scenarios cover transitive chains, overwrites, the CSR source and destination exclusions, and both kinds of store-conditional outcome. They also cover the sticky control set, and a retire that lands in the same cycle as the report it must mask.

// File: rtl/memdep_pkg.sv
package memdep_pkg;
  typedef enum logic [2:0] {
    MR_NONE    = 3'd0,
    MR_LOAD    = 3'd1,
    MR_STORE   = 3'd2,
    MR_AMO     = 3'd3,
    MR_LR      = 3'd4,
    MR_SC_OK   = 3'd5,
    MR_SC_FAIL = 3'd6
  } mem_role_e;

  typedef enum logic [2:0] {
    CK_RW  = 3'd0,
    CK_RS  = 3'd1,
    CK_RC  = 3'd2,
    CK_RWI = 3'd3,
    CK_RSI = 3'd4,
    CK_RCI = 3'd5
  } csr_kind_e;
endpackage

// File: rtl/memdep_csr_rules.sv
module memdep_csr_rules
  import memdep_pkg::*;
#(
  parameter int RIW = 5
) (
  input  logic           csr_en,
  input  logic [2:0]     csr_op,
  input  logic [RIW-1:0] rd,
  input  logic [RIW-1:0] rs1,
  output logic           rs1_is_reg,
  output logic           csr_src,
  output logic           csr_dst
);
  csr_kind_e kind;
  logic      imm_form;
  logic      rw_form;
  logic      setclr_form;

  always_comb begin
    kind        = csr_kind_e'(csr_op);
    imm_form    = kind inside {CK_RWI, CK_RSI, CK_RCI};
    rw_form     = kind inside {CK_RW, CK_RWI};
    setclr_form = kind inside {CK_RS, CK_RC, CK_RSI, CK_RCI};
    rs1_is_reg  = !(csr_en && imm_form);
    csr_src     = csr_en && !(rw_form && (rd == '0));
    csr_dst     = csr_en && !(setclr_form && (rs1 == '0));
  end
endmodule

// File: rtl/memdep_bank.sv
module memdep_bank #(
  parameter int N         = 32,
  parameter int W         = 16,
  parameter bit ZERO_HOLD = 1'b0,
  localparam int IW       = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [IW-1:0]       widx,
  input  logic [W-1:0]        wdata,
  input  logic [W-1:0]        clr_mask,
  output logic [N-1:0][W-1:0] q
);
  for (genvar e = 0; e < N; e++) begin : g_entry
    if (ZERO_HOLD && (e == 0)) begin : g_hard_zero
      assign q[e] = '0;
    end else begin : g_store
      logic [W-1:0] ent_q;
      logic [W-1:0] ent_d;
      logic         ent_en;
      logic         hit;

      always_comb begin
        hit    = we && (widx == IW'(e));
        ent_d  = (hit ? wdata : ent_q) & ~clr_mask;
        ent_en = hit || (|clr_mask);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ent_q <= '0;
        else if (ent_en) ent_q <= ent_d;
      end

      assign q[e] = ent_q;
    end
  end
endmodule

// File: rtl/memdep_tracker.sv
module memdep_tracker
  import memdep_pkg::*;
#(
  parameter int WIN  = 16,
  parameter int NREG = 32,
  parameter int NCSR = 4,
  localparam int IDW = $clog2(WIN),
  localparam int RIW = $clog2(NREG),
  localparam int CIW = $clog2(NCSR)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [RIW-1:0] in_rs1,
  input  logic [RIW-1:0] in_rs2,
  input  logic [RIW-1:0] in_rs3,
  input  logic [RIW-1:0] in_rd,
  input  logic           in_csr_en,
  input  logic [2:0]     in_csr_op,
  input  logic [CIW-1:0] in_csr_sel,
  input  logic           in_is_ctrl,
  input  logic [2:0]     in_mem,
  input  logic [IDW-1:0] in_op_id,
  input  logic           ret_valid,
  input  logic [IDW-1:0] ret_id,
  output logic           dep_valid,
  output logic [IDW-1:0] dep_id,
  output logic [WIN-1:0] dep_addr,
  output logic [WIN-1:0] dep_data,
  output logic [WIN-1:0] dep_ctrl
);
  logic [NREG-1:0][WIN-1:0] gpr_q;
  logic [NCSR-1:0][WIN-1:0] csr_q;
  logic [WIN-1:0] clr_mask, own_bit;
  logic [WIN-1:0] t1, t2, t3, tc, src_union;
  logic           rs1_is_reg, csr_src, csr_dst;
  mem_role_e      role;
  logic           is_memop, has_data, load_dst;
  logic           gpr_we, csr_we;
  logic [WIN-1:0] gpr_wdata;

  logic [WIN-1:0] ctrl_q, ctrl_d;
  logic           ctrl_en;
  logic           dv_d;
  logic [WIN-1:0] addr_d, data_d, cdep_d;

  memdep_csr_rules #(.RIW(RIW)) u_rules (
    .csr_en     (in_csr_en),
    .csr_op     (in_csr_op),
    .rd         (in_rd),
    .rs1        (in_rs1),
    .rs1_is_reg (rs1_is_reg),
    .csr_src    (csr_src),
    .csr_dst    (csr_dst)
  );

  always_comb begin
    clr_mask  = ret_valid ? (WIN'(1) << ret_id) : '0;
    own_bit   = WIN'(1) << in_op_id;
    role      = mem_role_e'(in_mem);
    is_memop  = role inside {MR_LOAD, MR_STORE, MR_AMO, MR_LR, MR_SC_OK};
    has_data  = role inside {MR_STORE, MR_AMO, MR_SC_OK};
    load_dst  = role inside {MR_LOAD, MR_AMO, MR_LR, MR_SC_OK};

    t1        = rs1_is_reg ? gpr_q[in_rs1] : '0;
    t2        = gpr_q[in_rs2];
    t3        = gpr_q[in_rs3];
    tc        = csr_src ? csr_q[in_csr_sel] : '0;
    src_union = t1 | t2 | t3 | tc;

    gpr_we    = in_valid && (in_rd != '0) && (role != MR_STORE);
    if (load_dst)               gpr_wdata = own_bit;
    else if (role == MR_SC_FAIL) gpr_wdata = '0;
    else                         gpr_wdata = src_union;

    csr_we    = in_valid && csr_dst && (role == MR_NONE);

    ctrl_en   = (in_valid && in_is_ctrl) || ret_valid;
    ctrl_d    = (ctrl_q | ((in_valid && in_is_ctrl) ? src_union : '0)) & ~clr_mask;

    dv_d      = in_valid && is_memop;
    addr_d    = t1 & ~clr_mask;
    data_d    = has_data ? (t2 & ~clr_mask) : '0;
    cdep_d    = ctrl_q & ~clr_mask;
  end

  memdep_bank #(.N(NREG), .W(WIN), .ZERO_HOLD(1'b1)) u_gpr (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (gpr_we),
    .widx     (in_rd),
    .wdata    (gpr_wdata),
    .clr_mask (clr_mask),
    .q        (gpr_q)
  );

  memdep_bank #(.N(NCSR), .W(WIN), .ZERO_HOLD(1'b0)) u_csr (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (csr_we),
    .widx     (in_csr_sel),
    .wdata    (src_union),
    .clr_mask (clr_mask),
    .q        (csr_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dep_valid <= 1'b0;
    else        dep_valid <= dv_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dep_id   <= '0;
      dep_addr <= '0;
      dep_data <= '0;
      dep_ctrl <= '0;
    end else if (dv_d) begin
      dep_id   <= in_op_id;
      dep_addr <= addr_d;
      dep_data <= data_d;
      dep_ctrl <= cdep_d;
    end
  end
endmodule

// File: rtl/memdep_tracker_chk.sv
module memdep_tracker_chk #(
  parameter int WIN  = 16,
  parameter int NREG = 32,
  parameter int NCSR = 4,
  localparam int IDW = $clog2(WIN),
  localparam int RIW = $clog2(NREG),
  localparam int CIW = $clog2(NCSR)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [RIW-1:0] in_rs1,
  input logic [RIW-1:0] in_rs2,
  input logic [RIW-1:0] in_rs3,
  input logic [RIW-1:0] in_rd,
  input logic           in_csr_en,
  input logic [2:0]     in_csr_op,
  input logic [CIW-1:0] in_csr_sel,
  input logic           in_is_ctrl,
  input logic [2:0]     in_mem,
  input logic [IDW-1:0] in_op_id,
  input logic           ret_valid,
  input logic [IDW-1:0] ret_id,
  input logic           dep_valid,
  input logic [IDW-1:0] dep_id,
  input logic [WIN-1:0] dep_addr,
  input logic [WIN-1:0] dep_data,
  input logic [WIN-1:0] dep_ctrl
);
  logic memop_in;
  assign memop_in = in_valid && (in_mem >= 3'd1) && (in_mem <= 3'd5);

  // R2: an operation addressed through register 0 reports no address taint
  a_r2_zero_reg_clean: assert property (@(posedge clk) disable iff (!rst_n)
    memop_in && (in_rs1 == '0) |=> dep_addr == '0);

  // R5: a failed store-conditional or a non-memory instruction gives no report
  a_r5_no_report: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ((in_mem == 3'd0) || (in_mem == 3'd6)) |=> !dep_valid);

  // R6: loads and load-reserved carry no data dependency
  a_r6_load_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ((in_mem == 3'd1) || (in_mem == 3'd4)) |=> dep_valid && (dep_data == '0));

  // R6: the report names the operation issued one cycle earlier
  a_r6_id_follows: assert property (@(posedge clk) disable iff (!rst_n)
    memop_in |=> dep_valid && (dep_id == $past(in_op_id)));

  // R10: a retired id never shows up in the following report
  a_r10_retired_gone: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> !dep_valid ||
      !(dep_addr[$past(ret_id)] || dep_data[$past(ret_id)] || dep_ctrl[$past(ret_id)]));
endmodule

bind memdep_tracker memdep_tracker_chk #(.WIN(WIN), .NREG(NREG), .NCSR(NCSR)) u_chk (.*);

// File: tb/memdep_tracker_test.sv
module memdep_tracker_test;
  localparam int WIN  = 16;
  localparam int NREG = 32;
  localparam int NCSR = 4;
  localparam int IDW  = $clog2(WIN);
  localparam int RIW  = $clog2(NREG);
  localparam int CIW  = $clog2(NCSR);

  localparam int M_NONE = 0, M_LOAD = 1, M_STORE = 2, M_AMO = 3, M_LR = 4, M_SCOK = 5, M_SCF = 6;
  localparam int C_RW = 0, C_RS = 1, C_RC = 2, C_RWI = 3, C_RSI = 4, C_RCI = 5;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           in_valid;
  logic [RIW-1:0] in_rs1, in_rs2, in_rs3, in_rd;
  logic           in_csr_en;
  logic [2:0]     in_csr_op;
  logic [CIW-1:0] in_csr_sel;
  logic           in_is_ctrl;
  logic [2:0]     in_mem;
  logic [IDW-1:0] in_op_id;
  logic           ret_valid;
  logic [IDW-1:0] ret_id;
  logic           dep_valid;
  logic [IDW-1:0] dep_id;
  logic [WIN-1:0] dep_addr, dep_data, dep_ctrl;

  int checks = 0;
  int fails  = 0;
  bit pend_ret = 1'b0;
  int pend_id  = 0;

  always #2 clk = ~clk;

  memdep_tracker #(.WIN(WIN), .NREG(NREG), .NCSR(NCSR)) uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    in_valid = 0; in_rs1 = '0; in_rs2 = '0; in_rs3 = '0; in_rd = '0;
    in_csr_en = 0; in_csr_op = '0; in_csr_sel = '0; in_is_ctrl = 0;
    in_mem = '0; in_op_id = '0; ret_valid = 0; ret_id = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    idle_inputs();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic op(input int m, input int rd, input int rs1, input int rs2, input int rs3,
                    input int id, input bit ctl, input bit cen, input int ck, input int sel);
    @(negedge clk);
    in_valid = 1; in_mem = 3'(m); in_rd = RIW'(rd); in_rs1 = RIW'(rs1);
    in_rs2 = RIW'(rs2); in_rs3 = RIW'(rs3); in_op_id = IDW'(id);
    in_is_ctrl = ctl; in_csr_en = cen; in_csr_op = 3'(ck); in_csr_sel = CIW'(sel);
    ret_valid = pend_ret; ret_id = IDW'(pend_id);
    @(negedge clk);
    idle_inputs();
    pend_ret = 0;
  endtask

  task automatic alu(input int rd, input int rs1, input int rs2, input int rs3);
    op(M_NONE, rd, rs1, rs2, rs3, 0, 0, 0, 0, 0);
  endtask
  task automatic mop(input int m, input int rd, input int rs1, input int rs2, input int id);
    op(m, rd, rs1, rs2, 0, id, 0, 0, 0, 0);
  endtask
  task automatic br(input int rs1, input int rs2);
    op(M_NONE, 0, rs1, rs2, 0, 0, 1, 0, 0, 0);
  endtask
  task automatic csr(input int ck, input int sel, input int rd, input int rs1);
    op(M_NONE, rd, rs1, 0, 0, 0, 0, 1, ck, sel);
  endtask
  task automatic retire(input int id);
    @(negedge clk);
    ret_valid = 1; ret_id = IDW'(id);
    @(negedge clk);
    ret_valid = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 valid low after reset", 32'(dep_valid), 0);
    mop(M_STORE, 0, 5, 6, 0);
    chk("R1 first report valid", 32'(dep_valid), 1);
    chk("R1 first addr empty", 32'(dep_addr), 0);
    chk("R1 first data empty", 32'(dep_data), 0);
    chk("R1 first ctrl empty", 32'(dep_ctrl), 0);
  endtask

  task automatic t_flow();
    mop(M_LOAD, 1, 0, 0, 1);
    alu(2, 1, 3, 0);
    alu(4, 2, 0, 0);
    mop(M_STORE, 0, 4, 0, 2);
    chk("R11 chain addr", 32'(dep_addr), 32'h0002);
    chk("R6 id", 32'(dep_id), 2);
    alu(4, 7, 0, 0);
    mop(M_STORE, 0, 4, 0, 3);
    chk("R3 overwrite clears", 32'(dep_addr), 0);
    mop(M_LOAD, 8, 0, 0, 4);
    mop(M_LOAD, 9, 0, 0, 5);
    alu(10, 8, 0, 9);
    mop(M_STORE, 0, 0, 10, 6);
    chk("R3 union via rs3 data", 32'(dep_data), 32'h0030);
    chk("R6 store addr x0", 32'(dep_addr), 0);
    mop(M_LOAD, 11, 10, 8, 7);
    chk("R6 load addr", 32'(dep_addr), 32'h0030);
    chk("R6 load no data", 32'(dep_data), 0);
    alu(0, 1, 0, 0);
    mop(M_STORE, 0, 0, 0, 7);
    chk("R2 x0 write dropped", 32'(dep_addr), 0);
  endtask

  task automatic t_atomics();
    mop(M_SCOK, 12, 0, 1, 8);
    chk("R6 sc data", 32'(dep_data), 32'h0002);
    mop(M_STORE, 0, 12, 0, 9);
    chk("R4 sc writes rd", 32'(dep_addr), 32'h0100);
    mop(M_SCF, 12, 0, 1, 10);
    chk("R5 failed sc no report", 32'(dep_valid), 0);
    mop(M_STORE, 0, 12, 0, 11);
    chk("R5 failed sc rd empty", 32'(dep_addr), 0);
    mop(M_AMO, 13, 8, 9, 12);
    chk("R6 amo addr", 32'(dep_addr), 32'h0010);
    chk("R6 amo data", 32'(dep_data), 32'h0020);
    mop(M_STORE, 0, 13, 0, 13);
    chk("R4 amo rd own id", 32'(dep_addr), 32'h1000);
  endtask

  task automatic t_retire();
    retire(1);
    mop(M_STORE, 0, 2, 0, 14);
    chk("R10 retire clears reg", 32'(dep_addr), 0);
    pend_ret = 1; pend_id = 4;
    mop(M_STORE, 0, 8, 0, 15);
    chk("R10 same-cycle retire masked", 32'(dep_addr), 0);
  endtask

  task automatic t_control();
    br(9, 0);
    mop(M_STORE, 0, 0, 0, 0);
    chk("R7 ctrl after branch", 32'(dep_ctrl), 32'h0020);
    alu(9, 0, 0, 0);
    mop(M_LR, 14, 0, 0, 1);
    chk("R7 ctrl sticky", 32'(dep_ctrl), 32'h0020);
    chk("R6 lr no data", 32'(dep_data), 0);
    retire(5);
    mop(M_STORE, 0, 0, 0, 2);
    chk("R10 retire clears ctrl", 32'(dep_ctrl), 0);
  endtask

  task automatic t_csr();
    do_reset();
    mop(M_LOAD, 3, 0, 0, 3);
    csr(C_RW, 1, 0, 3);
    csr(C_RS, 1, 5, 0);
    mop(M_STORE, 0, 5, 0, 4);
    chk("R8 R9 csr carries taint", 32'(dep_addr), 32'h0008);
    csr(C_RW, 1, 0, 0);
    csr(C_RS, 1, 6, 0);
    mop(M_STORE, 0, 6, 0, 5);
    chk("R8 rw rd0 not source", 32'(dep_addr), 0);
    mop(M_LOAD, 3, 0, 0, 5);
    csr(C_RW, 1, 0, 3);
    csr(C_RW, 1, 7, 0);
    mop(M_STORE, 0, 7, 0, 6);
    chk("R8 rw rd nonzero source", 32'(dep_addr), 32'h0020);
    mop(M_LOAD, 3, 0, 0, 6);
    csr(C_RSI, 1, 10, 3);
    mop(M_STORE, 0, 10, 0, 7);
    chk("R9 imm field not register", 32'(dep_addr), 32'h0020);
    csr(C_RWI, 1, 0, 3);
    csr(C_RS, 1, 11, 0);
    mop(M_STORE, 0, 11, 0, 8);
    chk("R9 rwi overwrites csr", 32'(dep_addr), 0);
    csr(C_RS, 2, 0, 3);
    csr(C_RC, 2, 12, 0);
    mop(M_STORE, 0, 12, 0, 9);
    chk("R9 set rs1 nonzero writes", 32'(dep_addr), 32'h0040);
    csr(C_RCI, 1, 13, 0);
    mop(M_STORE, 0, 13, 0, 10);
    chk("R9 other slot untouched", 32'(dep_addr), 0);
  endtask

  initial begin
    rst_n = 0;
    idle_inputs();
    t_reset();
    t_flow();
    t_atomics();
    t_retire();
    t_control();
    t_csr();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule